// File: doc/BRIEF.md
# Serial Flash Write Gate and Block Protection Controller

This block sits behind the command decoder of a serial NOR flash and decides whether each decoded command may run. It keeps the eight-bit status byte (busy flag, write-enable latch, three protect-level bits, a top/bottom selector and a status-lock bit). When a write-class command arrives, it checks the command against the write-enable latch, the framing reported by the front end, the protected address range and the lock input. It then accepts or rejects the command, times the self-timed operation with a counter and clears the write-enable latch when the operation ends.

The front end presents one command per `cmd_valid` pulse at the point where chip select rises. Each pulse carries the opcode, the 24-bit address, the number of data bytes clocked in after the address, the first data byte and a flag that says whether chip select rose on a byte boundary. One cycle after the pulse, exactly one of `cmd_accept` or `cmd_reject` goes high. An accepted erase or program also raises `wr_start` and presents the target start address and length to the array sequencer. The array itself is outside this block.

Top module: `flash_wprot_ctrl`

## Requirements
- R1: While reset is held and afterwards until the first command, the status byte reads 00h, power-down is off and no verdict or start pulse is raised.
- R2: Opcode 06h sets the write-enable latch (status bit 1) and 04h clears it. Both are accepted regardless of the current latch value.
- R3: Erase (20h, D7h, D8h, 60h, C7h), page program (02h) and status write (01h) are rejected while the write-enable latch is 0. Busy then stays 0.
- R4: An accepted write-class command sets busy (status bit 0) from the cycle after the command for exactly the configured cycle count of that operation. When busy falls, the write-enable latch reads 0.
- R5: Status write updates only status bits 7 and 5..2, and only when the operation completes. Bits 6, 1 and 0 ignore the written byte, and bit 6 always reads 0.
- R6: When status bit 7 is 1 and `wp_n` is low, status write is rejected. When `wp_n` is high, status write is accepted whatever bit 7 holds.
- R7: The protect field is {bit5 = side, bit4..2 = level}. If level bit 4 is 1, the whole array is protected. If the level is 000, nothing is protected. Otherwise level bits 3..2 = 1, 2 or 3 protect 64 KiB, 128 KiB or 256 KiB. With side 0 this range sits at the top of the array (from 070000h, 060000h or 040000h to 07FFFFh). With side 1 it sits at the bottom (from 000000h to 00FFFFh, 01FFFFh or 03FFFFh). Sector erase, small sector erase and page program aimed at a protected address are rejected.
- R8: Chip erase is accepted only when the level bits 4..2 are all 0.
- R9: A write-class command whose chip select rise is not byte-aligned is rejected. A status write with a data byte count other than 1 is rejected. A page program with no data bytes is rejected.
- R10: For an accepted page program, `wr_len` is the byte count capped at 256. `wr_addr` keeps the page bits A18..A8 of the command. Its low byte is A7..A0 when at most 256 bytes arrived. Otherwise it is A7..A0 plus the byte count, modulo 256, which is the column of the earliest of the last 256 bytes.
- R11: While busy, only status read (05h) is accepted. Every other opcode, including 06h, 04h and B9h, is rejected.
- R12: B9h, when accepted, enters power-down. In power-down only ABh is accepted, and it leaves power-down.
- R13: Exactly one of `cmd_accept` and `cmd_reject` pulses one cycle after each `cmd_valid`. A rejected command leaves the write-enable latch as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle pulse: a decoded command has ended with chip select rising |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 24 | Command address as shifted in |
| cmd_bytes | input | 12 | Count of whole data bytes received after the address |
| cmd_data | input | 8 | First data byte (status write value) |
| cmd_aligned | input | 1 | Chip select rose on an 8-clock boundary |
| wp_n | input | 1 | Write-protect pin level, active low |
| cmd_accept | output | 1 | Command accepted (one cycle after `cmd_valid`) |
| cmd_reject | output | 1 | Command rejected (one cycle after `cmd_valid`) |
| busy | output | 1 | Self-timed operation in progress |
| pdown | output | 1 | Power-down state |
| status | output | 8 | Status byte {lock, 0, side, level[2:0], write-enable, busy} |
| wr_start | output | 1 | Pulse: accepted erase or program starts |
| wr_kind | output | 3 | Operation kind: 1 small sector, 2 sector, 3 chip, 4 page program |
| wr_addr | output | 19 | Start address in the array |
| wr_len | output | 9 | Page program byte count (0 for erases) |

## Verification
The assertions assume that `cmd_valid` is a single-cycle pulse and that the front end never presents a command while the previous verdict is still pending. They also assume that `wp_n` changes only between commands. The bench drives every command as a one-cycle pulse on the falling clock edge, holds the lock input steady across each command, and waits for busy to drop before issuing a new write-class command, except in the scenario that exercises rejection while busy. Under these conditions each verdict can be attributed to a single command, and the write-enable and protect bits can be compared cycle by cycle.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_SSE_A = 8'h20;
    localparam logic [7:0] OP_SSE_B = 8'hD7;
    localparam logic [7:0] OP_SE    = 8'hD8;
    localparam logic [7:0] OP_CE_A  = 8'h60;
    localparam logic [7:0] OP_CE_B  = 8'hC7;
    localparam logic [7:0] OP_SLEEP = 8'hB9;
    localparam logic [7:0] OP_WAKE  = 8'hAB;

    localparam int PROT_BLK_W = 3;

    typedef enum logic [2:0] {
        WK_NONE = 3'd0,
        WK_SSE  = 3'd1,
        WK_SE   = 3'd2,
        WK_CE   = 3'd3,
        WK_PP   = 3'd4,
        WK_SRW  = 3'd5
    } wkind_e;

    typedef struct packed {
        logic       lock;
        logic       rsvd;
        logic       side;
        logic [2:0] level;
        logic       wel;
        logic       busy;
    } stat_t;

    function automatic wkind_e classify(input logic [7:0] op);
        case (op)
            OP_SSE_A, OP_SSE_B: return WK_SSE;
            OP_SE:              return WK_SE;
            OP_CE_A, OP_CE_B:   return WK_CE;
            OP_PP:              return WK_PP;
            OP_WRSR:            return WK_SRW;
            default:            return WK_NONE;
        endcase
    endfunction

    function automatic logic known_plain(input logic [7:0] op);
        case (op)
            OP_WREN, OP_WRDI, OP_RDSR, OP_SLEEP, OP_WAKE,
            8'h03, 8'h0B, 8'h3B, 8'hBB, 8'h9F: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/prot_range_chk.sv
module prot_range_chk
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              side,
    input  logic [2:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              none
);
    localparam int NBLK = 1 << PROT_BLK_W;

    logic [PROT_BLK_W-1:0] blk;
    logic [PROT_BLK_W:0]   span;
    logic [NBLK-1:0]       blk_prot;

    assign blk  = addr[ADDR_W-1 -: PROT_BLK_W];
    assign none = (level == 3'b000);

    always_comb begin
        span = '0;
        if (level[1:0] != 2'b00)
            span = (PROT_BLK_W+1)'(1) << (level[1:0] - 2'd1);
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        always_comb begin
            if (level[2])
                blk_prot[b] = 1'b1;
            else if (side)
                blk_prot[b] = (b < int'(span));
            else
                blk_prot[b] = (b >= NBLK - int'(span));
        end
    end

    assign hit = blk_prot[blk];
endmodule

// File: rtl/op_timer.sv
module op_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             running,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign done = running && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            running <= 1'b1;
        end else if (running) begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1))
                running <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int PAGE_BYTES = 256,
    parameter int BYTES_W    = 12,
    parameter int CNT_W      = 16,
    parameter int T_SSE      = 12,
    parameter int T_SE       = 16,
    parameter int T_CE       = 24,
    parameter int T_PP       = 8,
    parameter int T_SRW      = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_op,
    input  logic [23:0]        cmd_addr,
    input  logic [BYTES_W-1:0] cmd_bytes,
    input  logic [7:0]         cmd_data,
    input  logic               cmd_aligned,
    input  logic               wp_n,
    output logic               cmd_accept,
    output logic               cmd_reject,
    output logic               busy,
    output logic               pdown,
    output logic [7:0]         status,
    output logic               wr_start,
    output logic [2:0]         wr_kind,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [$clog2(PAGE_BYTES):0] wr_len
);
    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int LEN_W = COL_W + 1;

    stat_t            st;
    logic [7:0]       srw_val;
    logic             srw_run;
    wkind_e           kind;
    logic             prot_hit, prot_none;
    logic             tmr_run, tmr_done, tmr_load;
    logic [CNT_W-1:0] dur;
    logic             wr_ok, ok;
    logic [ADDR_W-1:0] a;
    logic [COL_W-1:0]  col;
    logic              over;

    assign a = cmd_addr[ADDR_W-1:0];

    prot_range_chk #(.ADDR_W(ADDR_W)) i_range (
        .side (st.side),
        .level(st.level),
        .addr (a),
        .hit  (prot_hit),
        .none (prot_none)
    );

    op_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(dur),
        .running (tmr_run),
        .done    (tmr_done)
    );

    always_comb begin
        kind = classify(cmd_op);
        case (kind)
            WK_SSE:  dur = CNT_W'(T_SSE);
            WK_SE:   dur = CNT_W'(T_SE);
            WK_CE:   dur = CNT_W'(T_CE);
            WK_PP:   dur = CNT_W'(T_PP);
            default: dur = CNT_W'(T_SRW);
        endcase

        wr_ok = 1'b0;
        if (kind != WK_NONE && !tmr_run && !pdown && st.wel && cmd_aligned) begin
            case (kind)
                WK_SSE, WK_SE: wr_ok = !prot_hit;
                WK_PP:         wr_ok = !prot_hit && (cmd_bytes != '0);
                WK_CE:         wr_ok = prot_none;
                WK_SRW:        wr_ok = (cmd_bytes == BYTES_W'(1)) && !(st.lock && !wp_n);
                default:       wr_ok = 1'b0;
            endcase
        end

        if (kind != WK_NONE)
            ok = wr_ok;
        else if (pdown)
            ok = (cmd_op == OP_WAKE);
        else if (tmr_run)
            ok = (cmd_op == OP_RDSR);
        else
            ok = known_plain(cmd_op);

        tmr_load = cmd_valid && wr_ok;

        over = (cmd_bytes > BYTES_W'(PAGE_BYTES));
        col  = over ? a[COL_W-1:0] + cmd_bytes[COL_W-1:0] : a[COL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= '0;
            srw_val    <= '0;
            srw_run    <= 1'b0;
            pdown      <= 1'b0;
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
            wr_start   <= 1'b0;
            wr_kind    <= '0;
            wr_addr    <= '0;
            wr_len     <= '0;
        end else begin
            cmd_accept <= cmd_valid && ok;
            cmd_reject <= cmd_valid && !ok;
            wr_start   <= 1'b0;

            if (tmr_done) begin
                st.wel <= 1'b0;
                if (srw_run) begin
                    st.lock  <= srw_val[7];
                    st.side  <= srw_val[5];
                    st.level <= srw_val[4:2];
                    srw_run  <= 1'b0;
                end
            end

            if (cmd_valid && ok) begin
                case (cmd_op)
                    OP_WREN:  st.wel <= 1'b1;
                    OP_WRDI:  st.wel <= 1'b0;
                    OP_SLEEP: pdown  <= 1'b1;
                    OP_WAKE:  pdown  <= 1'b0;
                    default:  ;
                endcase
                if (kind == WK_SRW) begin
                    srw_val <= cmd_data;
                    srw_run <= 1'b1;
                end else if (kind != WK_NONE) begin
                    wr_start <= 1'b1;
                    wr_kind  <= kind;
                    if (kind == WK_PP) begin
                        wr_addr <= {a[ADDR_W-1:COL_W], col};
                        wr_len  <= over ? LEN_W'(PAGE_BYTES) : cmd_bytes[LEN_W-1:0];
                    end else begin
                        wr_addr <= a;
                        wr_len  <= '0;
                    end
                end
            end
        end
    end

    assign busy   = tmr_run;
    assign status = {st.lock, 1'b0, st.side, st.level, st.wel, tmr_run};
endmodule

// File: rtl/flash_wprot_chk.sv
module flash_wprot_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic       cmd_accept,
    input logic       cmd_reject,
    input logic       pdown,
    input logic [7:0] status
);
    assert_one_verdict_R13: assert property (@(posedge clk) disable iff (rst)
        !(cmd_accept && cmd_reject));

    assert_verdict_follows_R13: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (cmd_accept || cmd_reject));

    assert_wel_kept_R13: assert property (@(posedge clk) disable iff (rst)
        (cmd_reject && !$fell(status[0])) |-> $stable(status[1]));

    assert_end_clears_wel_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(status[0]) |-> !status[1]);

    assert_busy_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> cmd_accept);

    assert_prot_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (status[0] && $past(status[0])) |-> $stable(status[7:2]));

    assert_pd_entry_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(pdown) |-> ($past(cmd_valid) && $past(cmd_op) == 8'hB9));

    assert_pd_only_wake_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(pdown) && cmd_accept) |-> ($past(cmd_op) == 8'hAB));
endmodule

bind flash_wprot_ctrl flash_wprot_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_accept(cmd_accept),
    .cmd_reject(cmd_reject),
    .pdown     (pdown),
    .status    (status)
);

// File: tb/test_flash_wprot_ctrl.sv
module test_flash_wprot_ctrl;
    localparam int T_SSE = 12, T_SE = 16, T_CE = 24, T_PP = 8, T_SRW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic [11:0] cmd_bytes = '0;
    logic [7:0]  cmd_data = '0;
    logic        cmd_aligned = 1'b1;
    logic        wp_n = 1'b1;
    logic        cmd_accept, cmd_reject, busy, pdown, wr_start;
    logic [7:0]  status;
    logic [2:0]  wr_kind;
    logic [18:0] wr_addr;
    logic [8:0]  wr_len;

    int n_chk = 0;
    int n_fail = 0;
    logic got_acc, got_rej;

    flash_wprot_ctrl i_flash_wprot_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_data(cmd_data),
        .cmd_aligned(cmd_aligned), .wp_n(wp_n), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .busy(busy), .pdown(pdown), .status(status),
        .wr_start(wr_start), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_len(wr_len)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] op, input logic [23:0] ad,
                         input int nb, input logic [7:0] dt, input logic al);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = ad;
        cmd_bytes = 12'(nb); cmd_data = dt; cmd_aligned = al;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_acc = cmd_accept;
        got_rej = cmd_reject;
    endtask

    task automatic expect_verdict(input logic acc, input string req, input string what);
        chk(got_acc == acc && got_rej == !acc, req, what, {got_acc, got_rej}, {acc, !acc});
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_status(input logic [7:0] v);
        int n;
        issue(8'h06, 0, 0, 0, 1);
        issue(8'h01, 0, 1, v, 1);
        wait_idle(n);
    endtask

    task automatic t_reset;
        chk(status == 8'h00 && !pdown && !cmd_accept && !cmd_reject && !wr_start,
            "R1", "reset state", status, 0);
    endtask

    task automatic t_wel;
        issue(8'h06, 0, 0, 0, 1);
        expect_verdict(1, "R2", "WREN verdict");
        chk(status[1] == 1, "R2", "wel after 06h", status[1], 1);
        issue(8'h06, 0, 0, 0, 1);
        chk(status[1] == 1, "R2", "wel after repeated 06h", status[1], 1);
        issue(8'h04, 0, 0, 0, 1);
        expect_verdict(1, "R2", "WRDI verdict");
        chk(status[1] == 0, "R2", "wel after 04h", status[1], 0);
    endtask

    task automatic t_no_wel;
        issue(8'hD8, 24'h000000, 0, 0, 1);
        expect_verdict(0, "R3", "sector erase without wel");
        chk(busy == 0 && status[1] == 0, "R3", "no busy after rejected erase", status, 0);
        issue(8'h02, 24'h000100, 4, 0, 1);
        expect_verdict(0, "R3", "program without wel");
        issue(8'h01, 0, 1, 8'h04, 1);
        expect_verdict(0, "R3", "status write without wel");
        chk(status == 8'h00, "R3", "status unchanged", status, 0);
    endtask

    task automatic t_durations;
        int n;
        issue(8'h06, 0, 0, 0, 1);
        issue(8'h20, 24'h001000, 0, 0, 1);
        expect_verdict(1, "R4", "small sector erase");
        chk(wr_start && wr_kind == 3'd1 && wr_addr == 19'h01000, "R4", "start SSE",
            wr_addr, 19'h01000);
        wait_idle(n);
        chk(n == T_SSE, "R4", "SSE busy cycles", n, T_SSE);
        chk(status[1] == 0, "R4", "wel cleared after SSE", status[1], 0);
        issue(8'h06, 0, 0, 0, 1);
        issue(8'hD8, 24'h020000, 0, 0, 1);
        wait_idle(n);
        chk(n == T_SE, "R4", "SE busy cycles", n, T_SE);
        issue(8'h06, 0, 0, 0, 1);
        issue(8'h02, 24'h000010, 3, 0, 1);
        wait_idle(n);
        chk(n == T_PP, "R4", "PP busy cycles", n, T_PP);
        chk(status[1] == 0, "R4", "wel cleared after PP", status[1], 0);
    endtask

    task automatic t_srw;
        int n;
        issue(8'h06, 0, 0, 0, 1);
        issue(8'h01, 0, 1, 8'hFF, 1);
        expect_verdict(1, "R5", "status write accepted");
        chk(status == 8'h03, "R5", "old bits during write", status, 8'h03);
        wait_idle(n);
        chk(n == T_SRW, "R4", "SRW busy cycles", n, T_SRW);
        chk(status == 8'hBC, "R5", "bits after write FFh", status, 8'hBC);
        set_status(8'h00);
        chk(status == 8'h00, "R5", "bits after write 00h", status, 0);
    endtask

    task automatic t_lock;
        set_status(8'h80);
        wp_n = 1'b0;
        issue(8'h06, 0, 0, 0, 1);
        issue(8'h01, 0, 1, 8'h00, 1);
        expect_verdict(0, "R6", "locked status write");
        chk(status == 8'h82, "R6", "lock keeps bits and wel", status, 8'h82);
        wp_n = 1'b1;
        issue(8'h01, 0, 1, 8'h00, 1);
        expect_verdict(1, "R6", "status write with wp_n high");
        begin int n; wait_idle(n); end
        chk(status == 8'h00, "R6", "lock removed", status, 0);
    endtask

    task automatic try_se(input logic [23:0] ad, input logic acc, input string what);
        int n;
        issue(8'h06, 0, 0, 0, 1);
        issue(8'hD8, ad, 0, 0, 1);
        expect_verdict(acc, "R7", what);
        if (acc) wait_idle(n);
        else begin
            chk(status[1] == 1 && !busy, "R13", "wel kept on protected hit", status[1], 1);
            issue(8'h04, 0, 0, 0, 1);
        end
    endtask

    task automatic t_prot;
        set_status(8'h04);
        try_se(24'h070000, 0, "top 1/8 hit");
        try_se(24'h06FFFF, 1, "top 1/8 miss");
        set_status(8'h08);
        try_se(24'h060000, 0, "top 1/4 hit");
        try_se(24'h05FFFF, 1, "top 1/4 miss");
        set_status(8'h0C);
        try_se(24'h040000, 0, "top 1/2 hit");
        try_se(24'h03FFFF, 1, "top 1/2 miss");
        set_status(8'h24);
        try_se(24'h00FFFF, 0, "bottom 1/8 hit");
        try_se(24'h010000, 1, "bottom 1/8 miss");
        set_status(8'h2C);
        try_se(24'h03FFFF, 0, "bottom 1/2 hit");
        try_se(24'h040000, 1, "bottom 1/2 miss");
        set_status(8'h10);
        try_se(24'h07FFFF, 0, "all, top");
        try_se(24'h000000, 0, "all, bottom");
        set_status(8'h20);
        try_se(24'h000000, 1, "side set, level none");
    endtask

    task automatic t_chip;
        int n;
        set_status(8'h24);
        issue(8'h06, 0, 0, 0, 1);
        issue(8'h60, 0, 0, 0, 1);
        expect_verdict(0, "R8", "chip erase with level set");
        issue(8'hC7, 0, 0, 0, 1);
        expect_verdict(0, "R8", "chip erase alt opcode with level set");
        set_status(8'h20);
        issue(8'h06, 0, 0, 0, 1);
        issue(8'hC7, 0, 0, 0, 1);
        expect_verdict(1, "R8", "chip erase with level none");
        wait_idle(n);
        chk(n == T_CE, "R4", "CE busy cycles", n, T_CE);
        set_status(8'h00);
    endtask

    task automatic t_frame;
        issue(8'h06, 0, 0, 0, 1);
        issue(8'hD8, 24'h000000, 0, 0, 0);
        expect_verdict(0, "R9", "misaligned erase");
        issue(8'h01, 0, 2, 8'h04, 1);
        expect_verdict(0, "R9", "status write two bytes");
        issue(8'h01, 0, 0, 8'h04, 1);
        expect_verdict(0, "R9", "status write no byte");
        issue(8'h02, 24'h000100, 0, 0, 1);
        expect_verdict(0, "R9", "program without data");
        chk(status == 8'h02, "R13", "wel kept after framing rejects", status, 8'h02);
        issue(8'h04, 0, 0, 0, 1);
    endtask

    task automatic t_page;
        int n;
        issue(8'h06, 0, 0, 0, 1);
        issue(8'h02, 24'h012345, 300, 0, 1);
        expect_verdict(1, "R10", "long program");
        chk(wr_start && wr_kind == 3'd4 && wr_addr == 19'h12371 && wr_len == 9'd256,
            "R10", "long program start addr", wr_addr, 19'h12371);
        wait_idle(n);
        issue(8'h06, 0, 0, 0, 1);
        issue(8'h02, 24'hF123FE, 5, 0, 1);
        chk(wr_addr == 19'h123FE && wr_len == 9'd5, "R10", "short program", wr_addr, 19'h123FE);
        wait_idle(n);
        issue(8'h06, 0, 0, 0, 1);
        issue(8'h02, 24'h000080, 256, 0, 1);
        chk(wr_addr == 19'h00080 && wr_len == 9'd256, "R10", "exact page", wr_len, 256);
        wait_idle(n);
    endtask

    task automatic t_busy;
        int n;
        issue(8'h06, 0, 0, 0, 1);
        issue(8'hD8, 24'h000000, 0, 0, 1);
        issue(8'h05, 0, 0, 0, 1);
        expect_verdict(1, "R11", "status read while busy");
        issue(8'h04, 0, 0, 0, 1);
        expect_verdict(0, "R11", "04h while busy");
        chk(status[1] == 1, "R11", "wel kept while busy", status[1], 1);
        issue(8'h03, 0, 0, 0, 1);
        expect_verdict(0, "R11", "read while busy");
        issue(8'hB9, 0, 0, 0, 1);
        expect_verdict(0, "R11", "B9h while busy");
        chk(!pdown, "R11", "no power-down while busy", pdown, 0);
        wait_idle(n);
    endtask

    task automatic t_pd;
        issue(8'hB9, 0, 0, 0, 1);
        expect_verdict(1, "R12", "enter power-down");
        chk(pdown == 1, "R12", "pdown set", pdown, 1);
        issue(8'h06, 0, 0, 0, 1);
        expect_verdict(0, "R12", "06h in power-down");
        chk(status[1] == 0, "R12", "wel untouched in power-down", status[1], 0);
        issue(8'h05, 0, 0, 0, 1);
        expect_verdict(0, "R12", "05h in power-down");
        issue(8'hAB, 0, 0, 0, 1);
        expect_verdict(1, "R12", "wake");
        chk(pdown == 0, "R12", "pdown cleared", pdown, 0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        chk(0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wel();
        t_no_wel();
        t_durations();
        t_srw();
        t_lock();
        t_prot();
        t_chip();
        t_frame();
        t_page();
        t_busy();
        t_pd();
        issue(8'h55, 0, 0, 0, 1);
        expect_verdict(0, "R13", "unknown opcode");
        finish_run();
    end
endmodule